// File: doc/BRIEF.md
# Privileged Set/Clear Interrupt-Enable Register

This block holds one enable bit for each of 32 error channels and uses those bits to gate the channels' error flags into a single combined interrupt line. Software reaches the enable state through a small memory-mapped register port. The state appears at two word addresses. At one address, a write sets every bit that carries a 1. At the other address, a write clears every bit that carries a 1. Bits written as 0 are left alone at both addresses, so firmware can change a few channels without first reading the register.

Reads are allowed in any access mode. A write changes the state only when the access carries the privilege flag. A write without the flag completes normally but changes nothing. Read data is registered and appears one cycle after the read strobe. The interrupt output is also registered, so it follows the error flags and the enables with one cycle of delay.

Top module: `irq_enable_ctrl`

## Requirements
- R1: After reset every enable bit is 0, the read data output is 0 and the interrupt output is 0.
- R2: A privileged write to word address 2 (byte offset 0x08) sets every enable bit whose write-data bit is 1. The new state is visible from the next cycle.
- R3: A privileged write to word address 3 (byte offset 0x0C) clears every enable bit whose write-data bit is 1. The new state is visible from the next cycle.
- R4: A write-data bit of 0 leaves the matching enable bit unchanged at both the set address and the clear address.
- R5: A write with the privilege flag low leaves the whole enable state unchanged at either address.
- R6: A read strobe at word address 2 or 3 returns the full enable state (bit n = channel n, 1 = enabled) on the read data output one cycle later, whatever the privilege flag. Both addresses return the same value.
- R7: A read at any other word address returns 0. A write to any other word address changes no enable bit.
- R8: The interrupt output equals the OR over all bits of (error flags AND enable state), both taken in the previous cycle.
- R9: When a read and a write happen in the same cycle, the read returns the enable state as it was before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| priv | input | 1 | Access is privileged when high |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| err_flags | input | 32 | Per-channel error flags |
| irq | output | 1 | Combined gated interrupt, registered |

## Verification
A register update and the functions that observe the enable state can fall in the same clock edge: a read of the same word, or the interrupt sampling the state. The bench provokes this by asserting a clear write and a read at the same address in one cycle while an enabled channel has its error flag raised. It then checks two things. The read must return the state from before the write. The interrupt must stay high for one more sample and drop on the sample after that, matching the one-cycle lag defined for both registered outputs.

// File: rtl/irq_en_pkg.sv
package irq_en_pkg;
  localparam int unsigned EN_W = 32;

  typedef logic [EN_W-1:0] en_vec_t;

  // OR the one bits of mask into the current state
  function automatic en_vec_t apply_set(en_vec_t cur, en_vec_t mask);
    return cur | mask;
  endfunction

  // remove the one bits of mask from the current state
  function automatic en_vec_t apply_clr(en_vec_t cur, en_vec_t mask);
    return cur & ~mask;
  endfunction

  // any channel with both its flag and its enable high
  function automatic logic any_gated(en_vec_t flags, en_vec_t en);
    return |(flags & en);
  endfunction
endpackage

// File: rtl/irq_en_decode.sv
module irq_en_decode #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned SET_WADDR = 2,
  parameter int unsigned CLR_WADDR = 3
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              priv,
  input  logic [ADDR_W-1:0] addr,
  output logic              set_stb,
  output logic              clr_stb,
  output logic              rd_hit
);
  localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_WADDR);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_WADDR);

  logic at_set, at_clr, wr_ok;

  assign at_set  = (addr == SET_A);
  assign at_clr  = (addr == CLR_A);
  assign wr_ok   = wr_en && priv;
  assign set_stb = wr_ok && at_set;
  assign clr_stb = wr_ok && at_clr;
  assign rd_hit  = rd_en && (at_set || at_clr);
endmodule

// File: rtl/irq_en_bank.sv
module irq_en_bank
  import irq_en_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    set_stb,
  input  logic    clr_stb,
  input  en_vec_t wdata,
  output en_vec_t en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (set_stb) en_q <= apply_set(en_q, wdata);
    else if (clr_stb) en_q <= apply_clr(en_q, wdata);
  end

  AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((en_q & $past(wdata)) == $past(wdata)));                  // R2
  AST_CLR_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((en_q & $past(wdata)) == '0));                            // R3
  AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb || clr_stb) |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata)))); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_stb || clr_stb) |=> $stable(en_q));                              // R4
endmodule

// File: rtl/irq_en_gate.sv
module irq_en_gate
  import irq_en_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  en_vec_t flags,
  input  en_vec_t en,
  output logic    irq_q
);
  logic irq_d;
  assign irq_d = any_gated(flags, en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q == (|($past(flags) & $past(en)))));                    // R8
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
  import irq_en_pkg::*;
#(
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned SET_BYTE_OFF = 8,
  parameter int unsigned CLR_BYTE_OFF = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [EN_W-1:0]   wdata,
  input  logic              priv,
  output logic [EN_W-1:0]   rdata,
  input  logic [EN_W-1:0]   err_flags,
  output logic              irq
);
  localparam int unsigned SET_WADDR = SET_BYTE_OFF / 4;
  localparam int unsigned CLR_WADDR = CLR_BYTE_OFF / 4;

  logic    set_stb, clr_stb, rd_hit;
  en_vec_t en_q;

  irq_en_decode #(
    .ADDR_W(ADDR_W), .SET_WADDR(SET_WADDR), .CLR_WADDR(CLR_WADDR)
  ) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .priv(priv), .addr(addr),
    .set_stb(set_stb), .clr_stb(clr_stb), .rd_hit(rd_hit)
  );

  irq_en_bank u_bank (
    .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .clr_stb(clr_stb),
    .wdata(wdata), .en_q(en_q)
  );

  irq_en_gate u_gate (
    .clk(clk), .rst_n(rst_n), .flags(err_flags), .en(en_q), .irq_q(irq)
  );

  // registered readback; unmapped or idle cycles give zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_hit) rdata <= en_q;
    else             rdata <= '0;
  end

  AST_USER_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !priv) |=> $stable(en_q));                                   // R5
  AST_RD_OLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (rdata == $past(en_q)));                                    // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |=> (rdata == '0));                                 // R7
  AST_ONE_VIEW_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_stb, clr_stb}));                                         // R2
endmodule

// File: tb/tb_irq_enable_ctrl.sv
module tb_irq_enable_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [3:0] A_SET = 4'd2;
  localparam logic [3:0] A_CLR = 4'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, priv = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, err_flags = '0, rdata;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] model = '0;
  logic [31:0] rd_val;

  irq_enable_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .priv(priv), .rdata(rdata), .err_flags(err_flags), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(logic [3:0] a, logic [31:0] d, logic p);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; priv = p;
    @(negedge clk);
    wr_en = 1'b0; priv = 1'b0; wdata = '0;
  endtask

  task automatic do_read(logic [3:0] a, logic p, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a; priv = p;
    @(negedge clk);
    rd_en = 1'b0; priv = 1'b0;
    v = rdata;
  endtask

  task automatic t_reset();
    check("R1 rdata", rdata, '0);
    check("R1 irq", {31'd0, irq}, '0);
    do_read(A_SET, 1'b1, rd_val); check("R1 set view", rd_val, '0);
    do_read(A_CLR, 1'b1, rd_val); check("R1 clr view", rd_val, '0);
    err_flags = '1;
    @(negedge clk); @(negedge clk);
    check("R1 irq with flags", {31'd0, irq}, '0);
    err_flags = '0;
  endtask

  task automatic t_set_clear();
    do_write(A_SET, 32'hA5A5_00FF, 1'b1); model = model | 32'hA5A5_00FF;
    do_read(A_SET, 1'b1, rd_val); check("R2 set", rd_val, model);
    do_write(A_SET, 32'h0000_F000, 1'b1); model = model | 32'h0000_F000;
    do_read(A_CLR, 1'b1, rd_val); check("R2 accumulate", rd_val, model);
    do_write(A_CLR, 32'h8001_00F0, 1'b1); model = model & ~32'h8001_00F0;
    do_read(A_SET, 1'b0, rd_val); check("R3 clear", rd_val, model);
    do_read(A_CLR, 1'b0, rd_val); check("R6 both views", rd_val, model);
  endtask

  task automatic t_zero_bits();
    do_write(A_SET, 32'h0, 1'b1);
    do_read(A_SET, 1'b1, rd_val); check("R4 set zeros", rd_val, model);
    do_write(A_CLR, 32'h0, 1'b1);
    do_read(A_CLR, 1'b1, rd_val); check("R4 clr zeros", rd_val, model);
  endtask

  task automatic t_user();
    do_write(A_SET, 32'hFFFF_FFFF, 1'b0);
    do_read(A_SET, 1'b0, rd_val); check("R5 user set", rd_val, model);
    do_write(A_CLR, 32'hFFFF_FFFF, 1'b0);
    do_read(A_CLR, 1'b0, rd_val); check("R5 user clr / R6 user read", rd_val, model);
  endtask

  task automatic t_unmapped();
    do_write(4'd0, 32'hFFFF_FFFF, 1'b1);
    do_write(4'd5, 32'hFFFF_FFFF, 1'b1);
    do_read(4'd0, 1'b1, rd_val); check("R7 read addr0", rd_val, '0);
    do_read(4'd5, 1'b1, rd_val); check("R7 read addr5", rd_val, '0);
    do_read(A_SET, 1'b1, rd_val); check("R7 state kept", rd_val, model);
  endtask

  task automatic t_irq();
    do_write(A_CLR, 32'hFFFF_FFFF, 1'b1);
    do_write(A_SET, 32'h0000_0010, 1'b1); model = 32'h0000_0010;
    @(negedge clk); err_flags = 32'h0000_0020;
    @(negedge clk); check("R8 disabled channel", {31'd0, irq}, '0);
    err_flags = 32'h0000_0030;
    check("R8 lag before edge", {31'd0, irq}, '0);
    @(negedge clk); check("R8 enabled channel", {31'd0, irq}, 32'd1);
    err_flags = '0;
    @(negedge clk); check("R8 flags gone", {31'd0, irq}, '0);
  endtask

  task automatic t_same_cycle();
    err_flags = 32'h0000_0010;
    @(negedge clk); @(negedge clk);
    check("R8 irq high", {31'd0, irq}, 32'd1);
    wr_en = 1'b1; rd_en = 1'b1; priv = 1'b1; addr = A_CLR; wdata = 32'h0000_0010;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; priv = 1'b0; wdata = '0;
    check("R9 read old state", rdata, 32'h0000_0010);
    check("R8 irq one more cycle", {31'd0, irq}, 32'd1);
    @(negedge clk);
    check("R8 irq dropped", {31'd0, irq}, '0);
    model = '0;
    do_read(A_CLR, 1'b1, rd_val); check("R9 new state", rd_val, model);
    err_flags = '0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_zero_bits();
    t_user();
    t_unmapped();
    t_irq();
    t_same_cycle();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule